// File: doc/BRIEF.md
# Dual I/O Window Decoder

This block decides whether a host I/O cycle belongs to a card socket. It holds two programmable address windows. Each window has an inclusive 16-bit lower and upper bound, written one byte at a time through an indexed register port. A shared enable register switches each window on or off. A shared control register gives each window a 4-bit attribute nibble: a fixed 16-bit width bit, a bit that hands the width decision to the card's 16-bit select line, a zero-wait-state request and a timing-set select.

The host offers a cycle by pulsing `io_valid` with the port address. A small controller latches the address, compares it against both windows and presents the result for one cycle: whether the cycle hit, which window was chosen, the effective bus width, the zero-wait request and the timing set. The controller has three states. `S_IDLE` waits for a request and takes the transition *accept* on `io_valid`. `S_DECODE` compares the latched address and samples `card_iocs16`, then takes *resolve* unconditionally. `S_RESULT` drives `res_valid` for one cycle and takes *retire* back to `S_IDLE`.

Top module: `io_win_decoder`

## Requirements
- R1: After reset every register reads back 0x00, `res_valid` is low and no window is enabled.
- R2: Window 0 lower bound is at index 0x08 (low byte) / 0x09 (high byte) and its upper bound at 0x0A / 0x0B. Window 1 uses 0x0C / 0x0D for the lower bound and 0x0E / 0x0F for the upper bound. Every register reads back what was last written to it. A write to an index with no register changes nothing, and that index reads back 0x00.
- R3: Index 0x06 holds the enables: bit 6 enables window 0 and bit 7 enables window 1. The other bits of that register have no effect on decoding. A disabled window never hits, whatever its bounds hold.
- R4: An enabled window hits when lower ≤ address ≤ upper. Both bounds are included.
- R5: When both windows hit, window 0 is reported (`win_sel` = 0).
- R6: Index 0x07 holds the attributes. Bits 3:0 belong to window 0 and bits 7:4 to window 1, with the same bit layout in each nibble.
- R7: In the chosen window's nibble, bit 1 set makes `wide16` equal `card_iocs16` as sampled in `S_DECODE`. With bit 1 clear, bit 0 gives `wide16` directly.
- R8: Nibble bit 2 is reported as `zero_wait` and nibble bit 3 as `timing_sel` for the chosen window.
- R9: A request accepted at clock edge k gives `res_valid` high for exactly one cycle, after edge k+1. `io_valid` is ignored while the controller is in `S_DECODE` or `S_RESULT`.
- R10: On a miss, `hit`, `win_sel`, `wide16`, `zero_wait` and `timing_sel` are all 0 during `res_valid`.
- R11: A window whose lower bound is above its upper bound never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for write and read-back |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the register at `reg_idx` (combinational) |
| io_valid | input | 1 | Host I/O cycle request |
| io_addr | input | 16 | Host I/O port address |
| card_iocs16 | input | 1 | Card's 16-bit select line |
| res_valid | output | 1 | Decode result valid (one cycle) |
| hit | output | 1 | Cycle falls in an enabled window |
| win_sel | output | 1 | Index of the chosen window |
| wide16 | output | 1 | Effective 16-bit data width |
| zero_wait | output | 1 | Zero-wait-state request of the chosen window |
| timing_sel | output | 1 | Timing set of the chosen window |

## Verification
The assertions assume that the window registers and `card_iocs16` are not changed between accepting a request and retiring its result. The bench therefore programs the registers only while the controller is idle and holds `card_iocs16` steady through each whole cycle. They also assume `io_valid` is low during reset, which the bench ensures by driving it low before releasing reset. One scenario deliberately holds `io_valid` high across `S_DECODE` with a different address, to show that the later request is dropped.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
    localparam int ATTR_W      = 4;
    localparam int ATTR_FIX16  = 0;
    localparam int ATTR_IOCS   = 1;
    localparam int ATTR_ZWS    = 2;
    localparam int ATTR_TSEL   = 3;

    localparam int IDX_ENABLE  = 8'h06;
    localparam int IDX_ATTR    = 8'h07;
    localparam int IDX_WINBASE = 8'h08;
    localparam int EN_BIT_BASE = 6;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DECODE = 2'd1,
        S_RESULT = 2'd2
    } dec_state_t;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [7:0]                       wdata,
    output logic [7:0]                       rdata,
    output logic [NUM_WIN-1:0]               win_en,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lo,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_hi,
    output logic [NUM_WIN-1:0][ATTR_W-1:0]   win_attr
);
    localparam int NBYTES  = ADDR_W / 8;
    localparam int WSTRIDE = 2 * NBYTES;

    logic [7:0]                     en_q;
    logic [7:0]                     attr_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] lo_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            attr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (wr) begin
            if (idx == IDX_W'(IDX_ENABLE)) en_q   <= wdata;
            if (idx == IDX_W'(IDX_ATTR))   attr_q <= wdata;
            for (int w = 0; w < NUM_WIN; w++) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (idx == IDX_W'(IDX_WINBASE + w*WSTRIDE + b))
                        lo_q[w][b*8 +: 8] <= wdata;
                    if (idx == IDX_W'(IDX_WINBASE + w*WSTRIDE + NBYTES + b))
                        hi_q[w][b*8 +: 8] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (idx == IDX_W'(IDX_ENABLE)) rdata = en_q;
        if (idx == IDX_W'(IDX_ATTR))   rdata = attr_q;
        for (int w = 0; w < NUM_WIN; w++) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (idx == IDX_W'(IDX_WINBASE + w*WSTRIDE + b))
                    rdata = lo_q[w][b*8 +: 8];
                if (idx == IDX_W'(IDX_WINBASE + w*WSTRIDE + NBYTES + b))
                    rdata = hi_q[w][b*8 +: 8];
            end
        end
    end

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_fields
            assign win_en[w]   = en_q[EN_BIT_BASE + w];
            assign win_attr[w] = attr_q[w*ATTR_W +: ATTR_W];
            assign win_lo[w]   = lo_q[w];
            assign win_hi[w]   = hi_q[w];
        end
    endgenerate
endmodule

// File: rtl/io_win_match.sv
module io_win_match #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              en,
    output logic              hit
);
    logic above_lo;
    logic below_hi;

    assign above_lo = (addr >= lo);
    assign below_hi = (addr <= hi);
    assign hit      = en & above_lo & below_hi;
endmodule

// File: rtl/io_win_ctrl.sv
module io_win_ctrl
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           io_valid,
    input  logic [ADDR_W-1:0]              io_addr,
    input  logic                           card_iocs16,
    input  logic [NUM_WIN-1:0]             win_hit,
    input  logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr,
    output logic [ADDR_W-1:0]              addr_lat,
    output logic                           res_valid,
    output logic                           hit,
    output logic [SEL_W-1:0]               win_sel,
    output logic                           wide16,
    output logic                           zero_wait,
    output logic                           timing_sel
);
    dec_state_t state_q, state_d;

    logic              any_hit;
    logic [SEL_W-1:0]  sel_d;
    logic [ATTR_W-1:0] attr_d;
    logic              wide_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: accept, resolve, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (io_valid) state_d = S_DECODE;
            S_DECODE: state_d = S_RESULT;
            S_RESULT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // lowest-numbered hitting window wins
    always_comb begin
        sel_d   = '0;
        any_hit = |win_hit;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) sel_d = SEL_W'(i);
        end
        attr_d = any_hit ? win_attr[sel_d] : '0;
        wide_d = attr_d[ATTR_IOCS] ? card_iocs16 : attr_d[ATTR_FIX16];
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat   <= '0;
            hit        <= 1'b0;
            win_sel    <= '0;
            wide16     <= 1'b0;
            zero_wait  <= 1'b0;
            timing_sel <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (io_valid) addr_lat <= io_addr;
                end
                S_DECODE: begin
                    hit        <= any_hit;
                    win_sel    <= sel_d;
                    wide16     <= any_hit & wide_d;
                    zero_wait  <= attr_d[ATTR_ZWS];
                    timing_sel <= attr_d[ATTR_TSEL];
                end
                S_RESULT: ;
                default: ;
            endcase
        end
    end

    assign res_valid = (state_q == S_RESULT);
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 8,
    localparam int SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              card_iocs16,
    output logic              res_valid,
    output logic              hit,
    output logic [SEL_W-1:0]  win_sel,
    output logic              wide16,
    output logic              zero_wait,
    output logic              timing_sel
);
    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_lo;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_hi;
    logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr;
    logic [NUM_WIN-1:0]             win_hit;
    logic [ADDR_W-1:0]              addr_lat;

    io_win_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .win_en   (win_en),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .win_attr (win_attr)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
            io_win_match #(.ADDR_W(ADDR_W)) u_match (
                .addr (addr_lat),
                .lo   (win_lo[w]),
                .hi   (win_hi[w]),
                .en   (win_en[w]),
                .hit  (win_hit[w])
            );
        end
    endgenerate

    io_win_ctrl #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_valid    (io_valid),
        .io_addr     (io_addr),
        .card_iocs16 (card_iocs16),
        .win_hit     (win_hit),
        .win_attr    (win_attr),
        .addr_lat    (addr_lat),
        .res_valid   (res_valid),
        .hit         (hit),
        .win_sel     (win_sel),
        .wide16      (wide16),
        .zero_wait   (zero_wait),
        .timing_sel  (timing_sel)
    );
endmodule

// File: rtl/io_win_decoder_chk.sv
module io_win_decoder_chk
    import io_win_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           io_valid,
    input logic                           card_iocs16,
    input logic                           res_valid,
    input logic                           hit,
    input logic [SEL_W-1:0]               win_sel,
    input logic                           wide16,
    input logic                           zero_wait,
    input logic                           timing_sel,
    input logic [ADDR_W-1:0]              addr_lat,
    input logic [NUM_WIN-1:0]             win_en,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_lo,
    input logic [NUM_WIN-1:0][ADDR_W-1:0] win_hi,
    input logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr
);
    logic w0_covers;
    assign w0_covers = win_en[0] && (addr_lat >= win_lo[0]) && (addr_lat <= win_hi[0]);

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_req_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(io_valid, 2));

    assert_hit_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && hit) |-> (win_en[win_sel] && addr_lat >= win_lo[win_sel]
                                && addr_lat <= win_hi[win_sel]));

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && win_en == '0) |-> !hit);

    assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && hit && win_sel != '0) |-> !w0_covers);

    assert_iocs_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && hit && win_attr[win_sel][ATTR_IOCS]) |-> (wide16 == $past(card_iocs16)));

    assert_miss_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !hit) |-> (!wide16 && !zero_wait && !timing_sel && win_sel == '0));
endmodule

bind io_win_decoder io_win_decoder_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_valid    (io_valid),
    .card_iocs16 (card_iocs16),
    .res_valid   (res_valid),
    .hit         (hit),
    .win_sel     (win_sel),
    .wide16      (wide16),
    .zero_wait   (zero_wait),
    .timing_sel  (timing_sel),
    .addr_lat    (addr_lat),
    .win_en      (win_en),
    .win_lo      (win_lo),
    .win_hi      (win_hi),
    .win_attr    (win_attr)
);

// File: tb/io_win_decoder_bench.sv
module io_win_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_idx = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        card_iocs16 = 1'b0;
    logic        res_valid, hit, wide16, zero_wait, timing_sel;
    logic [0:0]  win_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    io_win_decoder u_io_win_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_valid(io_valid),
        .io_addr(io_addr), .card_iocs16(card_iocs16), .res_valid(res_valid),
        .hit(hit), .win_sel(win_sel), .wide16(wide16), .zero_wait(zero_wait),
        .timing_sel(timing_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] idx, logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] idx, logic [7:0] exp);
        @(negedge clk);
        reg_idx = idx;
        #1 check(req, reg_rdata, exp);
    endtask

    // result fields packed {hit, sel, wide, zws, tsel}
    task automatic io_cycle(string req, logic [15:0] addr, logic iocs, logic [4:0] exp);
        @(negedge clk);
        io_valid = 1'b1; io_addr = addr; card_iocs16 = iocs;
        @(negedge clk);
        io_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, res_valid, 1'b1);
        check(req, {hit, win_sel, wide16, zero_wait, timing_sel}, exp);
        @(negedge clk);
        check({req, " pulse end"}, res_valid, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 res_valid", res_valid, 1'b0);
        for (int i = 6; i < 16; i++) rd_check("R1 reg zero", 8'(i), 8'h00);
        io_cycle("R1 nothing enabled", 16'h0000, 1'b0, 5'b00000);
    endtask

    task automatic t_program;
        wr_reg(8'h08, 8'h00); wr_reg(8'h09, 8'h03);
        wr_reg(8'h0A, 8'h1F); wr_reg(8'h0B, 8'h03);
        wr_reg(8'h0C, 8'h10); wr_reg(8'h0D, 8'h03);
        wr_reg(8'h0E, 8'h00); wr_reg(8'h0F, 8'h04);
        rd_check("R2 w0 lo low", 8'h08, 8'h00);
        rd_check("R2 w0 lo high", 8'h09, 8'h03);
        rd_check("R2 w0 hi low", 8'h0A, 8'h1F);
        rd_check("R2 w1 lo low", 8'h0C, 8'h10);
        rd_check("R2 w1 hi high", 8'h0F, 8'h04);
        wr_reg(8'h20, 8'h5A);
        rd_check("R2 unmapped index", 8'h20, 8'h00);
        rd_check("R2 unmapped no side effect", 8'h08, 8'h00);
    endtask

    task automatic t_disabled;
        io_cycle("R3 both disabled", 16'h0300, 1'b0, 5'b00000);
        wr_reg(8'h06, 8'h3F);
        io_cycle("R3 other enable bits", 16'h0310, 1'b0, 5'b00000);
    endtask

    task automatic t_bounds;
        wr_reg(8'h06, 8'h40);
        io_cycle("R4 below lo", 16'h02FF, 1'b0, 5'b00000);
        io_cycle("R4 at lo", 16'h0300, 1'b0, 5'b10000);
        io_cycle("R4 at hi", 16'h031F, 1'b0, 5'b10000);
        io_cycle("R4 above hi", 16'h0320, 1'b0, 5'b00000);
    endtask

    task automatic t_priority;
        wr_reg(8'h06, 8'hC0);
        io_cycle("R5 overlap w0 wins", 16'h0315, 1'b0, 5'b10000);
        io_cycle("R4 w1 only", 16'h0320, 1'b0, 5'b11000);
        io_cycle("R4 w1 at hi", 16'h0400, 1'b0, 5'b11000);
        io_cycle("R10 past w1", 16'h0401, 1'b1, 5'b00000);
        wr_reg(8'h06, 8'h80);
        io_cycle("R3 w0 off w1 takes", 16'h0315, 1'b0, 5'b11000);
        wr_reg(8'h06, 8'hC0);
    endtask

    task automatic t_attrs;
        wr_reg(8'h07, 8'hA5);
        rd_check("R6 attr readback", 8'h07, 8'hA5);
        io_cycle("R6 R8 w0 nibble", 16'h0300, 1'b0, 5'b10110);
        io_cycle("R7 w1 iocs low", 16'h0320, 1'b0, 5'b11001);
        io_cycle("R7 w1 iocs high", 16'h0320, 1'b1, 5'b11101);
        wr_reg(8'h07, 8'h03);
        io_cycle("R7 iocs overrides fixed", 16'h0300, 1'b0, 5'b10000);
        io_cycle("R7 iocs follows card", 16'h0300, 1'b1, 5'b10100);
        io_cycle("R10 miss clears", 16'h0500, 1'b1, 5'b00000);
        wr_reg(8'h07, 8'h00);
    endtask

    task automatic t_inverted;
        wr_reg(8'h08, 8'h00); wr_reg(8'h09, 8'h05);
        wr_reg(8'h0A, 8'hFF); wr_reg(8'h0B, 8'h04);
        io_cycle("R11 at lo", 16'h0500, 1'b0, 5'b00000);
        io_cycle("R11 at hi", 16'h04FF, 1'b0, 5'b00000);
    endtask

    task automatic t_busy_ignore;
        // w1 covers 0x0310..0x0400; second request held during DECODE must be dropped
        @(negedge clk);
        io_valid = 1'b1; io_addr = 16'h0320;
        @(negedge clk);
        io_addr = 16'h0900;
        @(negedge clk);
        io_valid = 1'b0;
        check("R9 result valid", res_valid, 1'b1);
        check("R9 first address decoded", {hit, win_sel}, 2'b11);
        @(negedge clk);
        check("R9 busy request dropped", res_valid, 1'b0);
        @(negedge clk);
        check("R9 no second result", res_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_program;
        t_disabled;
        t_bounds;
        t_priority;
        t_attrs;
        t_busy_ignore;
        t_inverted;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule